// File: doc/BRIEF.md
# Frame-Rate-Control Greyscale Ditherer

This block turns a 4-bit grey level into one on/off dot for a monochrome panel. Each grey level stands for a duty cycle, a fraction of frames and neighbouring dots that are lit. Every duty cycle with a period of 3, 4, 5 or 7 frames has a programmable bit pattern made of 4-bit nibbles. One nibble of the pattern is active per frame, and the active nibble moves on at every frame start. Inside that nibble, the dot's column modulo 4 picks the bit. Level 15 is always lit and level 0 is always dark. The six fractions below one half that have no pattern of their own use the inverse of their complementary pattern.

Pixel data, column index and a frame-start strobe come from the display fetch path. The eight pattern values come in as ports, normally held by a register file. The block copies them into shadow registers at each frame start, so a frame never mixes two patterns. The result appears one clock after the pixel, with a matching valid flag.

Top module: `frc_dither`

## Requirements
- R1: While reset is active and in the first cycle after it, `dot_valid` and `dot_on` are 0. All frame-phase counters start at 0.
- R2: `dot_valid` equals `pix_valid` delayed by exactly one clock. `dot_on` is 0 in every cycle in which `dot_valid` is 0.
- R3: Level 15 yields `dot_on` = 1 and level 0 yields `dot_on` = 0, whatever the phase, column or patterns.
- R4: Levels 14, 13, 12, 11, 10, 9, 8 and 7 use the 6/7, 4/5, 3/4, 5/7, 2/3, 3/5, 4/7 and 2/4 patterns. The output is bit (column mod 4) of nibble p of the shadowed pattern, where nibble 0 is bits 3:0 and p is the phase counter for that pattern's period.
- R5: Levels 6, 5, 4, 3, 2 and 1 give the inverse of the bit that levels 8, 9, 10, 11, 13 and 14 would give for the same pixel, phase and patterns.
- R6: There is one phase counter for each period (3, 4, 5, 7). Each counter rises by one at every `frame_start` and wraps from period-1 back to 0. Without `frame_start` it holds its value.
- R7: After reset the shadow patterns are 2/3 = 0x7DA, 3/4 = 0x7DBE, 2/4 = 0xA5A5, 4/5 = 0x7DFBE, 3/5 = 0x7A5AD, 6/7 = 0xFBFDFE7, 5/7 = 0x7B5ADEF and 4/7 = 0xB9DC663.
- R8: A change on a pattern port has no effect on `dot_on` until the next `frame_start`. That strobe loads the ports into the shadows and advances the phases. A pixel presented in the same cycle as `frame_start` still uses the old phases and patterns.
- R9: Only the two low bits of `pix_col` affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_level | input | 4 | Grey level of the pixel |
| pix_col | input | COL_W (10) | Column of the pixel |
| duty_2of3 | input | 12 | 2/3 pattern, 3 nibbles |
| duty_3of4 | input | 16 | 3/4 pattern, 4 nibbles |
| duty_2of4 | input | 16 | 2/4 pattern, 4 nibbles |
| duty_4of5 | input | 20 | 4/5 pattern, 5 nibbles |
| duty_3of5 | input | 20 | 3/5 pattern, 5 nibbles |
| duty_6of7 | input | 28 | 6/7 pattern, 7 nibbles |
| duty_5of7 | input | 28 | 5/7 pattern, 7 nibbles |
| duty_4of7 | input | 28 | 4/7 pattern, 7 nibbles |
| dot_valid | output | 1 | `dot_on` carries a result |
| dot_on | output | 1 | Dithered dot value |

## Verification
The first sweep runs every level against columns 0 to 7 before any frame start, with random values already on the pattern ports. A mismatch there separates the reset defaults from values that leaked through the ports too early. Sweeps over more than seven frames with fresh random patterns tell apart the four phase counters and their wrap points, the nibble order, and the inverted lower levels from their partners. Further passes cover port changes made in mid-frame, a pixel that coincides with a frame strobe, and high column numbers that differ only above bit 1.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int NIB_W     = 4;
  localparam int NUM_PATS  = 8;
  localparam int NUM_CTRS  = 4;
  localparam int PH_W      = 3;
  localparam int PAT_BUS_W = 32;

  typedef logic [PAT_BUS_W-1:0] pat_bus_t;
  typedef logic [PH_W-1:0]      phase_t;

  // pattern slot numbering
  localparam int P_2OF3 = 0;
  localparam int P_3OF4 = 1;
  localparam int P_2OF4 = 2;
  localparam int P_4OF5 = 3;
  localparam int P_3OF5 = 4;
  localparam int P_6OF7 = 5;
  localparam int P_5OF7 = 6;
  localparam int P_4OF7 = 7;

  typedef enum logic [1:0] {K_DARK, K_LIT, K_PAT} level_kind_e;

  typedef struct packed {
    level_kind_e kind;
    logic [2:0]  slot;
    logic        inv;
  } level_map_t;

  function automatic int ctr_period(input int c);
    case (c)
      0: return 3;
      1: return 4;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int pat_ctr(input int p);
    case (p)
      P_2OF3: return 0;
      P_3OF4, P_2OF4: return 1;
      P_4OF5, P_3OF5: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int pat_width(input int p);
    return NIB_W * ctr_period(pat_ctr(p));
  endfunction

  function automatic pat_bus_t pat_default(input int p);
    case (p)
      P_2OF3: return 32'h0000_07DA;
      P_3OF4: return 32'h0000_7DBE;
      P_2OF4: return 32'h0000_A5A5;
      P_4OF5: return 32'h0007_DFBE;
      P_3OF5: return 32'h0007_A5AD;
      P_6OF7: return 32'h0FBF_DFE7;
      P_5OF7: return 32'h07B5_ADEF;
      default: return 32'h0B9D_C663;
    endcase
  endfunction

  function automatic level_map_t map_level(input logic [3:0] lvl);
    level_map_t m;
    m.kind = K_PAT;
    m.inv  = 1'b0;
    m.slot = 3'(P_2OF3);
    case (lvl)
      4'd15: m.kind = K_LIT;
      4'd0:  m.kind = K_DARK;
      4'd14: m.slot = 3'(P_6OF7);
      4'd13: m.slot = 3'(P_4OF5);
      4'd12: m.slot = 3'(P_3OF4);
      4'd11: m.slot = 3'(P_5OF7);
      4'd10: m.slot = 3'(P_2OF3);
      4'd9:  m.slot = 3'(P_3OF5);
      4'd8:  m.slot = 3'(P_4OF7);
      4'd7:  m.slot = 3'(P_2OF4);
      4'd6:  begin m.slot = 3'(P_4OF7); m.inv = 1'b1; end
      4'd5:  begin m.slot = 3'(P_3OF5); m.inv = 1'b1; end
      4'd4:  begin m.slot = 3'(P_2OF3); m.inv = 1'b1; end
      4'd3:  begin m.slot = 3'(P_5OF7); m.inv = 1'b1; end
      4'd2:  begin m.slot = 3'(P_4OF5); m.inv = 1'b1; end
      default: begin m.slot = 3'(P_6OF7); m.inv = 1'b1; end
    endcase
    return m;
  endfunction

  // bit (col) of nibble (phase): index = phase*4 + col
  function automatic logic pick_bit(input pat_bus_t pat, input phase_t ph,
                                    input logic [1:0] col);
    return pat[{ph, col}];
  endfunction

  function automatic phase_t next_phase(input phase_t ph, input int period);
    return (int'(ph) == period - 1) ? '0 : ph + 1'b1;
  endfunction
endpackage

// File: rtl/frc_phase_ctr.sv
module frc_phase_ctr
  import frc_pkg::*;
#(
  parameter int PERIOD = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (advance) phase <= next_phase(phase, PERIOD);
  end
endmodule

// File: rtl/frc_pattern_shadow.sv
module frc_pattern_shadow
  import frc_pkg::*;
#(
  parameter int       WIDTH     = 12,
  parameter pat_bus_t RESET_VAL = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  pat_bus_t d,
  output pat_bus_t q
);
  logic [WIDTH-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= RESET_VAL[WIDTH-1:0];
    else if (load) held <= d[WIDTH-1:0];
  end

  generate
    if (WIDTH < PAT_BUS_W) begin : g_pad
      assign q = {{(PAT_BUS_W-WIDTH){1'b0}}, held};
    end else begin : g_full
      assign q = held;
    end
  endgenerate
endmodule

// File: rtl/frc_level_select.sv
module frc_level_select
  import frc_pkg::*;
(
  input  pat_bus_t   pats   [NUM_PATS],
  input  phase_t     phases [NUM_CTRS],
  input  logic [3:0] level,
  input  logic [1:0] col,
  output logic       bit_out
);
  phase_t pat_phase [NUM_PATS];

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PATS; gp++) begin : g_ph
      assign pat_phase[gp] = phases[pat_ctr(gp)];
    end
  endgenerate

  level_map_t m;
  always_comb begin
    m = map_level(level);
    case (m.kind)
      K_LIT:   bit_out = 1'b1;
      K_DARK:  bit_out = 1'b0;
      default: bit_out = pick_bit(pats[m.slot], pat_phase[m.slot], col) ^ m.inv;
    endcase
  end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
  import frc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [3:0]       pix_level,
  input  logic [COL_W-1:0] pix_col,
  input  logic [11:0]      duty_2of3,
  input  logic [15:0]      duty_3of4,
  input  logic [15:0]      duty_2of4,
  input  logic [19:0]      duty_4of5,
  input  logic [19:0]      duty_3of5,
  input  logic [27:0]      duty_6of7,
  input  logic [27:0]      duty_5of7,
  input  logic [27:0]      duty_4of7,
  output logic             dot_valid,
  output logic             dot_on
);
  localparam logic [COL_W-1:0] COL_MASK = COL_W'(3);

  // named events for the checker
  logic       frame_tick;
  logic       pix_fire;
  logic       raw_bit;
  logic [1:0] col_lo;
  phase_t     phase3_w;
  phase_t     phase7_w;

  assign frame_tick = frame_start;
  assign pix_fire   = pix_valid;
  assign col_lo     = 2'(pix_col & COL_MASK);

  pat_bus_t pat_in  [NUM_PATS];
  pat_bus_t pat_q   [NUM_PATS];
  phase_t   phase_q [NUM_CTRS];

  assign pat_in[P_2OF3] = PAT_BUS_W'(duty_2of3);
  assign pat_in[P_3OF4] = PAT_BUS_W'(duty_3of4);
  assign pat_in[P_2OF4] = PAT_BUS_W'(duty_2of4);
  assign pat_in[P_4OF5] = PAT_BUS_W'(duty_4of5);
  assign pat_in[P_3OF5] = PAT_BUS_W'(duty_3of5);
  assign pat_in[P_6OF7] = PAT_BUS_W'(duty_6of7);
  assign pat_in[P_5OF7] = PAT_BUS_W'(duty_5of7);
  assign pat_in[P_4OF7] = PAT_BUS_W'(duty_4of7);

  genvar gc, gs;
  generate
    for (gc = 0; gc < NUM_CTRS; gc++) begin : g_ctr
      frc_phase_ctr #(.PERIOD(ctr_period(gc))) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (frame_tick),
        .phase   (phase_q[gc])
      );
    end
    for (gs = 0; gs < NUM_PATS; gs++) begin : g_shadow
      frc_pattern_shadow #(
        .WIDTH     (pat_width(gs)),
        .RESET_VAL (pat_default(gs))
      ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_tick),
        .d     (pat_in[gs]),
        .q     (pat_q[gs])
      );
    end
  endgenerate

  assign phase3_w = phase_q[0];
  assign phase7_w = phase_q[3];

  frc_level_select u_sel (
    .pats    (pat_q),
    .phases  (phase_q),
    .level   (pix_level),
    .col     (col_lo),
    .bit_out (raw_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_valid <= 1'b0;
      dot_on    <= 1'b0;
    end else begin
      dot_valid <= pix_fire;
      dot_on    <= pix_fire & raw_bit;
    end
  end
endmodule

// File: rtl/frc_dither_chk.sv
module frc_dither_chk
  import frc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic       pix_fire,
  input logic [3:0] pix_level,
  input phase_t     phase3_w,
  input phase_t     phase7_w,
  input logic       dot_valid,
  input logic       dot_on
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fire |=> dot_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_fire |=> !dot_valid);
  // R2
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_valid |-> !dot_on);
  // R3
  full_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && pix_level == 4'd15) |=> dot_on);
  // R3
  full_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && pix_level == 4'd0) |=> !dot_on);
  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase7_w < 3'd7) && (phase3_w < 3'd3));
  // R6
  phase7_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && phase7_w == 3'd6) |=> phase7_w == 3'd0);
  // R6
  phase3_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && phase3_w == 3'd0) |=> phase3_w == 3'd1);
  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(phase7_w) && $stable(phase3_w)));
endmodule

bind frc_dither frc_dither_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .pix_fire   (pix_fire),
  .pix_level  (pix_level),
  .phase3_w   (phase3_w),
  .phase7_w   (phase7_w),
  .dot_valid  (dot_valid),
  .dot_on     (dot_on)
);

// File: tb/frc_dither_test.sv
`timescale 1ns/1ps
module frc_dither_test;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_start = 1'b0;
  logic             pix_valid = 1'b0;
  logic [3:0]       pix_level = '0;
  logic [COL_W-1:0] pix_col = '0;
  logic [11:0]      duty_2of3 = '0;
  logic [15:0]      duty_3of4 = '0;
  logic [15:0]      duty_2of4 = '0;
  logic [19:0]      duty_4of5 = '0;
  logic [19:0]      duty_3of5 = '0;
  logic [27:0]      duty_6of7 = '0;
  logic [27:0]      duty_5of7 = '0;
  logic [27:0]      duty_4of7 = '0;
  logic             dot_valid;
  logic             dot_on;

  always #5 clk = ~clk;

  frc_dither #(.COL_W(COL_W)) uut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic exp; string tag; int lvl; int col; } item_t;
  item_t sb[$];

  // bench model: shadows in slot order 2/3,3/4,2/4,4/5,3/5,6/7,5/7,4/7
  logic [31:0] m_pat [8] = '{32'h7DA, 32'h7DBE, 32'hA5A5, 32'h7DFBE,
                             32'h7A5AD, 32'hFBFDFE7, 32'h7B5ADEF, 32'hB9DC663};
  int m_ph3 = 0, m_ph4 = 0, m_ph5 = 0, m_ph7 = 0;
  string ctx = "";

  function automatic logic nib_bit(input logic [31:0] p, input int ph, input int c);
    logic [3:0] n;
    n = 4'((p >> (4 * ph)) & 32'hF);
    return n[c % 4];
  endfunction

  function automatic logic model(input int lvl, input int c, output string tag);
    int  s;
    int  ph;
    bit  inv;
    inv = 0;
    tag = "R4";
    if (lvl == 15) begin tag = "R3"; return 1'b1; end
    if (lvl == 0)  begin tag = "R3"; return 1'b0; end
    if (lvl < 7) begin
      inv = 1;
      tag = "R5";
      lvl = (lvl == 6) ? 8 : (lvl == 5) ? 9 : (lvl == 4) ? 10 :
            (lvl == 3) ? 11 : (lvl == 2) ? 13 : 14;
    end
    case (lvl)
      14: begin s = 5; ph = m_ph7; end
      13: begin s = 3; ph = m_ph5; end
      12: begin s = 1; ph = m_ph4; end
      11: begin s = 6; ph = m_ph7; end
      10: begin s = 0; ph = m_ph3; end
      9:  begin s = 4; ph = m_ph5; end
      8:  begin s = 7; ph = m_ph7; end
      default: begin s = 2; ph = m_ph4; end
    endcase
    return nib_bit(m_pat[s], ph, c) ^ inv;
  endfunction

  task automatic randomize_ports();
    duty_2of3 = 12'($urandom);
    duty_3of4 = 16'($urandom);
    duty_2of4 = 16'($urandom);
    duty_4of5 = 20'($urandom);
    duty_3of5 = 20'($urandom);
    duty_6of7 = 28'($urandom);
    duty_5of7 = 28'($urandom);
    duty_4of7 = 28'($urandom);
  endtask

  // driver: called just after a falling edge, returns at the next one
  task automatic step(input bit fs, input bit v, input int lvl, input int c);
    item_t it;
    string t;
    frame_start = fs;
    pix_valid   = v;
    pix_level   = 4'(lvl);
    pix_col     = COL_W'(c);
    if (v) begin
      it.exp = model(lvl, c, t);
      it.tag = {t, ctx};
      it.lvl = lvl;
      it.col = c;
      sb.push_back(it);
    end
    if (fs) begin
      m_pat[0] = 32'(duty_2of3); m_pat[1] = 32'(duty_3of4);
      m_pat[2] = 32'(duty_2of4); m_pat[3] = 32'(duty_4of5);
      m_pat[4] = 32'(duty_3of5); m_pat[5] = 32'(duty_6of7);
      m_pat[6] = 32'(duty_5of7); m_pat[7] = 32'(duty_4of7);
      m_ph3 = (m_ph3 + 1) % 3; m_ph4 = (m_ph4 + 1) % 4;
      m_ph5 = (m_ph5 + 1) % 5; m_ph7 = (m_ph7 + 1) % 7;
    end
    @(negedge clk);
  endtask

  task automatic sweep(input int col_base, input bit gaps);
    for (int l = 0; l < 16; l++) begin
      for (int c = 0; c < 8; c++) begin
        step(0, 1, l, col_base + c);
        if (gaps && ((l + c) % 5 == 0)) step(0, 0, 0, 0);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dot_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R2: dot_valid=1 with no pixel pending (actual 1, expected 0)");
        end else begin
          item_t it;
          it = sb.pop_front();
          if (dot_on !== it.exp) begin
            fails++;
            $display("FAIL %s: level %0d col %0d dot_on actual %b expected %b",
                     it.tag, it.lvl, it.col, dot_on, it.exp);
          end
        end
      end else if (dot_on !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R2: idle dot_on actual %b expected 0", dot_on);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dot_valid !== 1'b0 || dot_on !== 1'b0) begin
      fails++;
      $display("FAIL R1: in reset valid/on actual %b%b expected 00", dot_valid, dot_on);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dot_valid !== 1'b0 || dot_on !== 1'b0) begin
      fails++;
      $display("FAIL R1: after reset valid/on actual %b%b expected 00", dot_valid, dot_on);
    end

    // defaults in use while ports already carry other values (R7, R8)
    randomize_ports();
    ctx = " R7 R8";
    sweep(0, 0);

    // frame sweeps across all phase wraps (R6), high columns (R9)
    for (int f = 0; f < 9; f++) begin
      ctx = " R6";
      step(1, 0, 0, 0);
      randomize_ports();
      if (f % 2 == 0) sweep(0, 1);
      else begin
        ctx = " R6 R9";
        sweep(1016, 1);
      end
    end

    // pixel coinciding with frame strobe (R8)
    ctx = " R8";
    for (int l = 1; l < 15; l++) begin
      randomize_ports();
      step(1, 1, l, l % 4);
      step(0, 1, l, l % 4);
    end

    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: results outstanding actual %0d expected 0", sb.size());
    end
    finish_run();
  end
endmodule